// File: doc/BRIEF.md
# Vector Destination Policy Merge Unit

This block forms the final image written back to one vector destination register. It receives the register's previous contents, the freshly computed result image, the mask register contents, the active vector length, the element width, the register grouping (or the effective grouping for segment accesses) and an instruction class code. From these it decides, for every element slot, one of four outcomes: take the new result, keep the old value, or apply the tail policy or the mask policy. A policy set to agnostic either keeps the old value or fills the element with ones. A build-time parameter fixes which of the two is used, so results are repeatable.

A pipeline stage places the block right before the register-file write port. Each accepted request produces one registered merged image and one write-enable a cycle later. For a request that covers several registers of a group, the issuing logic sends one request per register and gives the position of that register within the group. The block then computes the element index that belongs to each slot.

Top module: `vdp_policy_merge`

## Requirements
- R1: `in_ready` is high whenever reset is low. A request accepted on a rising edge sets `out_valid` high after that edge for exactly one cycle, and `out_img` and `out_we` are valid at the same time. While the synchronous active-high `rst` is asserted, `out_valid` is low.
- R2: The element width code `sew` is 0=8, 1=16, 2=32 or 3=64 bits. Slot j of the register at group position `grp_idx` holds element index `grp_idx*(VLEN/width)+j`. A body element that is active takes the new result.
- R3: An element whose index is at or above `vl` is a tail element. With `vta`=0 it keeps its old value. With `vta`=1 it is agnostic, and by default it is filled with ones.
- R4: With `vm`=0 (masked), element i is inactive when bit i of `v0_mask` is 0, whatever the element width. With `vma`=0 an inactive element keeps its old value. With `vma`=1 it is agnostic. With `vm`=1 no element is inactive.
- R5: `lmul` codes 0..3 select groups of 1, 2, 4 and 8 registers, and codes 7, 6 and 5 select 1/2, 1/4 and 1/8. With a fractional code, the slots beyond the used fraction of the register are tail elements, even when their index is below `vl`.
- R6: Class 1 (mask destination) treats every bit as one element. Bits at or above `vl` are tail and always agnostic, whatever `vta` says. Masked-off body bits follow `vma`. Mask-register logical operations use this class with `vm`=1.
- R7: Class 2 covers carry/borrow arithmetic, merge, move and compress. These have no inactive elements: every body element takes the new result, and neither `v0_mask` nor `vma` has any effect.
- R8: Class 3 (reduction) places the new result in slot 0 of the register whatever the mask and `vma`. Every other slot is tail and follows `vta`.
- R9: Class 4 (store) never asserts `out_we`.
- R10: When `vl` is 0, every non-store class returns the old image unchanged with `out_we` high. Class 0 is the ordinary element-wise class.
- R11: With parameter `FILL_ONES`=0, agnostic elements keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| old_img | input | VLEN | Previous destination register contents |
| new_img | input | VLEN | Computed result image |
| v0_mask | input | VLEN | Mask register, bit i for element i |
| vl | input | clog2(VLEN+1) | Active vector length |
| sew | input | 2 | Element width code |
| lmul | input | 3 | Signed register grouping code (effective grouping for segments) |
| grp_idx | input | 3 | Position of this register within its group |
| vm | input | 1 | 1 = unmasked, 0 = masked by v0_mask |
| vta | input | 1 | Tail policy, 1 = agnostic |
| vma | input | 1 | Mask policy, 1 = agnostic |
| op_class | input | 3 | Instruction class code |
| out_valid | output | 1 | Merged result present |
| out_img | output | VLEN | Merged register image |
| out_we | output | 1 | Register write-enable |

## Verification
All results are registered once. `out_img`, `out_we` and `out_valid` belong to a request accepted on a given rising edge and appear right after that same edge. Inputs are driven on the falling edge, and the bench samples the outputs on the following falling edge, half a period after the capture. One more falling edge later it confirms that `out_valid` has dropped. Expected images come from per-byte outcome masks in the vector table, or from bit patterns derived by hand for mask destinations. None of them comes from the design.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
  // instruction classes
  localparam logic [2:0] OPC_ELEM    = 3'd0;
  localparam logic [2:0] OPC_MASKDST = 3'd1;
  localparam logic [2:0] OPC_NOMASK  = 3'd2;
  localparam logic [2:0] OPC_REDUCE  = 3'd3;
  localparam logic [2:0] OPC_STORE   = 3'd4;

  // per-element outcome
  localparam logic [1:0] CL_NEW   = 2'd0;
  localparam logic [1:0] CL_TAIL  = 2'd1;
  localparam logic [1:0] CL_INACT = 2'd2;
  localparam logic [1:0] CL_HOLD  = 2'd3;
endpackage

// File: rtl/vdp_elem_class.sv
module vdp_elem_class
  import vdp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [1:0]                 sew,
  input  logic [2:0]                 lmul,
  input  logic [2:0]                 grp_idx,
  input  logic [$clog2(VLEN+1)-1:0]  vl,
  input  logic                       vm,
  input  logic [VLEN-1:0]            v0_mask,
  input  logic [2:0]                 op_class,
  output logic [1:0]                 cls [VLEN/8]
);
  localparam int NB  = VLEN / 8;
  localparam int NBL = $clog2(NB);
  localparam int EW  = $clog2(VLEN);
  localparam int VLW = $clog2(VLEN + 1);

  logic           frac;
  logic [1:0]     fsh;
  logic [NBL:0]   used;
  logic           is_red;
  logic           is_nomask;

  // slots of this register that belong to the group
  always_comb begin
    frac      = lmul[2] && (lmul != 3'b100);
    fsh       = 2'(4'd8 - {1'b0, lmul});
    used      = (NBL+1)'(NB) >> sew;
    if (frac) used = used >> fsh;
    is_red    = (op_class == OPC_REDUCE);
    is_nomask = (op_class == OPC_NOMASK);
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [NBL-1:0] slot;
    logic [EW-1:0]  eidx;
    logic           past_vl;
    logic           beyond;
    logic           off;
    logic [1:0]     c_b;

    always_comb begin
      slot    = NBL'(b) >> sew;
      eidx    = (EW'(grp_idx) << (NBL - int'(sew))) + EW'(slot);
      past_vl = VLW'(eidx) >= vl;
      beyond  = {1'b0, slot} >= used;
      off     = !vm && !v0_mask[eidx];
      if (vl == '0)                c_b = CL_HOLD;
      else if (is_red)             c_b = (slot == '0) ? CL_NEW : CL_TAIL;
      else if (past_vl || beyond)  c_b = CL_TAIL;
      else if (off && !is_nomask)  c_b = CL_INACT;
      else                         c_b = CL_NEW;
    end

    assign cls[b] = c_b;
  end
endmodule

// File: rtl/vdp_bit_class.sv
module vdp_bit_class
  import vdp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [$clog2(VLEN+1)-1:0]  vl,
  input  logic                       vm,
  input  logic [VLEN-1:0]            v0_mask,
  output logic [1:0]                 cls [VLEN]
);
  localparam int VLW = $clog2(VLEN + 1);

  for (genvar i = 0; i < VLEN; i++) begin : g_bit
    logic [1:0] c_i;
    always_comb begin
      if (vl == '0)                   c_i = CL_HOLD;
      else if (VLW'(i) >= vl)         c_i = CL_TAIL;
      else if (!vm && !v0_mask[i])    c_i = CL_INACT;
      else                            c_i = CL_NEW;
    end
    assign cls[i] = c_i;
  end
endmodule

// File: rtl/vdp_merge_sel.sv
module vdp_merge_sel
  import vdp_pkg::*;
#(
  parameter int VLEN      = 128,
  parameter bit FILL_ONES = 1'b1
) (
  input  logic [VLEN-1:0] old_img,
  input  logic [VLEN-1:0] new_img,
  input  logic [1:0]      elem_cls [VLEN/8],
  input  logic [1:0]      bit_cls  [VLEN],
  input  logic            bitwise,
  input  logic            vta,
  input  logic            vma,
  output logic [VLEN-1:0] merged
);
  for (genvar i = 0; i < VLEN; i++) begin : g_sel
    logic [1:0] c;
    logic       agn;
    assign c   = bitwise ? bit_cls[i] : elem_cls[i/8];
    // mask destinations always treat the tail as agnostic
    assign agn = (c == CL_TAIL)  ? (vta | bitwise) :
                 (c == CL_INACT) ? vma : 1'b0;
    assign merged[i] = (c == CL_NEW)        ? new_img[i] :
                       (agn && FILL_ONES)   ? 1'b1 : old_img[i];
  end
endmodule

// File: rtl/vdp_policy_merge.sv
module vdp_policy_merge
  import vdp_pkg::*;
#(
  parameter int VLEN      = 128,
  parameter bit FILL_ONES = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [VLEN-1:0]            old_img,
  input  logic [VLEN-1:0]            new_img,
  input  logic [VLEN-1:0]            v0_mask,
  input  logic [$clog2(VLEN+1)-1:0]  vl,
  input  logic [1:0]                 sew,
  input  logic [2:0]                 lmul,
  input  logic [2:0]                 grp_idx,
  input  logic                       vm,
  input  logic                       vta,
  input  logic                       vma,
  input  logic [2:0]                 op_class,
  output logic                       out_valid,
  output logic [VLEN-1:0]            out_img,
  output logic                       out_we
);
  logic [1:0]      elem_cls [VLEN/8];
  logic [1:0]      bit_cls  [VLEN];
  logic [VLEN-1:0] merged;
  logic            is_store;
  logic            bitwise;

  assign is_store = (op_class == OPC_STORE);
  assign bitwise  = (op_class == OPC_MASKDST);
  assign in_ready = !rst;

  vdp_elem_class #(.VLEN(VLEN)) u_elem (
    .sew(sew), .lmul(lmul), .grp_idx(grp_idx), .vl(vl), .vm(vm),
    .v0_mask(v0_mask), .op_class(op_class), .cls(elem_cls)
  );

  vdp_bit_class #(.VLEN(VLEN)) u_bit (
    .vl(vl), .vm(vm), .v0_mask(v0_mask), .cls(bit_cls)
  );

  vdp_merge_sel #(.VLEN(VLEN), .FILL_ONES(FILL_ONES)) u_sel (
    .old_img(old_img), .new_img(new_img), .elem_cls(elem_cls),
    .bit_cls(bit_cls), .bitwise(bitwise), .vta(vta), .vma(vma),
    .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_img <= is_store ? old_img : merged;
      out_we  <= !is_store;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  // R9
  store_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == OPC_STORE) |=> !out_we);

  // R10
  write_we_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class != OPC_STORE) |=> out_we);

  // R10
  zero_vl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vl == '0) |=> out_img == $past(old_img));

  // R8
  reduce_tail_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == OPC_REDUCE && !vta && sew == 2'd0 && vl != '0)
    |=> out_img[VLEN-1:8] == $past(old_img[VLEN-1:8]));
endmodule

// File: tb/vdp_policy_merge_test.sv
module vdp_policy_merge_test;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready, in_ready_k;
  logic [VLEN-1:0]  old_img, new_img, v0_mask;
  logic [7:0]       vl;
  logic [1:0]       sew;
  logic [2:0]       lmul, grp_idx, op_class;
  logic             vm, vta, vma;
  logic             out_valid, out_we, out_valid_k, out_we_k;
  logic [VLEN-1:0]  out_img, out_img_k;

  always #10 clk = ~clk;  // 50 MHz

  vdp_policy_merge #(.VLEN(VLEN), .FILL_ONES(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .old_img(old_img), .new_img(new_img), .v0_mask(v0_mask), .vl(vl),
    .sew(sew), .lmul(lmul), .grp_idx(grp_idx), .vm(vm), .vta(vta),
    .vma(vma), .op_class(op_class), .out_valid(out_valid),
    .out_img(out_img), .out_we(out_we)
  );

  vdp_policy_merge #(.VLEN(VLEN), .FILL_ONES(1'b0)) uut_keep (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_k),
    .old_img(old_img), .new_img(new_img), .v0_mask(v0_mask), .vl(vl),
    .sew(sew), .lmul(lmul), .grp_idx(grp_idx), .vm(vm), .vta(vta),
    .vma(vma), .op_class(op_class), .out_valid(out_valid_k),
    .out_img(out_img_k), .out_we(out_we_k)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [1:0]  sew;
    logic [2:0]  lmul;
    logic [2:0]  grp;
    logic [7:0]  vl;
    logic        vm, vta, vma;
    logic [15:0] v0;
    logic [15:0] newm;   // bytes expected to take the new value
    logic [15:0] onem;   // bytes expected to be all ones
    logic        we;
  } vec_t;

  localparam int NV = 13;
  // old bytes 3C, new bytes C3, fill FF
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd0, 2'd0, 3'd0, 3'd0, 8'd16, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h0000, 1'b1}, // R2 full body
    '{4'd3,  3'd0, 2'd0, 3'd0, 3'd0, 8'd10, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h03FF, 16'hFC00, 1'b1}, // R3 tail agnostic
    '{4'd3,  3'd0, 2'd0, 3'd0, 3'd0, 8'd10, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h03FF, 16'h0000, 1'b1}, // R3 tail undisturbed
    '{4'd4,  3'd0, 2'd1, 3'd0, 3'd0, 8'd5,  1'b0, 1'b0, 1'b1, 16'h0015, 16'h0333, 16'h00CC, 1'b1}, // R4 masked sew16
    '{4'd2,  3'd0, 2'd2, 3'd1, 3'd1, 8'd6,  1'b1, 1'b1, 1'b0, 16'h0000, 16'h00FF, 16'hFF00, 1'b1}, // R2 group position 1
    '{4'd5,  3'd0, 2'd1, 3'd6, 3'd0, 8'd5,  1'b1, 1'b1, 1'b0, 16'h0000, 16'h000F, 16'hFFF0, 1'b1}, // R5 quarter register
    '{4'd7,  3'd2, 2'd0, 3'd0, 3'd0, 8'd16, 1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'h0000, 1'b1}, // R7 mask ignored
    '{4'd8,  3'd3, 2'd2, 3'd0, 3'd0, 8'd7,  1'b0, 1'b1, 1'b1, 16'h0000, 16'h000F, 16'hFFF0, 1'b1}, // R8 reduction agn
    '{4'd8,  3'd3, 2'd3, 3'd0, 3'd0, 8'd7,  1'b0, 1'b0, 1'b1, 16'h0000, 16'h00FF, 16'h0000, 1'b1}, // R8 reduction und
    '{4'd9,  3'd4, 2'd0, 3'd0, 3'd0, 8'd16, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R9 store
    '{4'd10, 3'd0, 2'd0, 3'd0, 3'd0, 8'd0,  1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R10 vl zero
    '{4'd4,  3'd0, 2'd0, 3'd0, 3'd0, 8'd16, 1'b0, 1'b1, 1'b0, 16'h00F0, 16'h00F0, 16'h0000, 1'b1}, // R4 undisturbed
    '{4'd10, 3'd3, 2'd0, 3'd0, 3'd0, 8'd0,  1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1}  // R10 reduction vl zero
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check_img(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s image act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] bytes_exp(input logic [15:0] newm, input logic [15:0] onem);
    logic [VLEN-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b*8 +: 8] = newm[b] ? 8'hC3 : (onem[b] ? 8'hFF : 8'h3C);
    return r;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] s, input logic [2:0] l,
                       input logic [2:0] g, input logic [7:0] n, input logic m,
                       input logic ta, input logic ma, input logic [VLEN-1:0] msk,
                       input logic [VLEN-1:0] o, input logic [VLEN-1:0] nw);
    @(negedge clk);
    op_class = op; sew = s; lmul = l; grp_idx = g; vl = n;
    vm = m; vta = ta; vma = ma; v0_mask = msk; old_img = o; new_img = nw;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    old_img = '0; new_img = '0; v0_mask = '0; vl = '0; sew = '0;
    lmul = '0; grp_idx = '0; op_class = '0; vm = 1'b1; vta = 1'b0; vma = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1", "out_valid in reset", out_valid, 1'b0);
    check_bit("R1", "in_ready in reset", in_ready, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1", "in_ready after reset", in_ready, 1'b1);
    check_bit("R1", "out_valid idle", out_valid, 1'b0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[k].req);
      drive(VECS[k].op, VECS[k].sew, VECS[k].lmul, VECS[k].grp, VECS[k].vl,
            VECS[k].vm, VECS[k].vta, VECS[k].vma, {112'h0, VECS[k].v0},
            {NB{8'h3C}}, {NB{8'hC3}});
      check_bit("R1", "out_valid after accept", out_valid, 1'b1);
      check_bit(tag, "write enable", out_we, VECS[k].we);
      if (VECS[k].we)
        check_img(tag, out_img, bytes_exp(VECS[k].newm, VECS[k].onem));
      if (k == 1)  // R11 keep-old fill on the second instance
        check_img("R11", out_img_k, bytes_exp(16'h03FF, 16'h0000));
      @(negedge clk);
      check_bit("R1", "out_valid drops", out_valid, 1'b0);
    end

    // R6 mask destination: tail forced agnostic although vta=0, inactive bits agnostic
    drive(3'd1, 2'd0, 3'd0, 3'd0, 8'd20, 1'b0, 1'b0, 1'b1,
          {108'h0, 20'h0F0F0}, '0, '0);
    check_img("R6", out_img, {{108{1'b1}}, 20'hF0F0F});
    // R6 inactive bits undisturbed with vma=0
    drive(3'd1, 2'd0, 3'd0, 3'd0, 8'd20, 1'b0, 1'b0, 1'b0,
          {108'h0, 20'h0F0F0}, '0, '1);
    check_img("R6", out_img, {{108{1'b1}}, 20'h0F0F0});
    // R11 mask-destination tail keeps old value without fill
    check_img("R11", out_img_k, {108'h0, 20'h0F0F0});

    // R1 reset in flight clears out_valid
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_bit("R1", "out_valid under reset", out_valid, 1'b0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule